// File: doc/BRIEF.md
# Thermal Throttling Policy Controller

The controller watches one temperature reading per functional unit block and decides how hard to throttle the chip. Readings arrive as unsigned integer degrees Celsius, each with its own valid strobe. The controller keeps the latest reading of every unit. It acts on those readings only at the end of each aggregation period, which is `PERIOD` cycles long (25000 by default). At that point it applies whichever of four policies the mode input selects:

- stop the global clock;
- gate input fetch of one pipeline stage;
- scale the whole chip's voltage and frequency;
- scale each unit's clock domain on its own.

A scale request means a fixed 20 % reduction that the supply logic applies. Every change in scaling state must be followed by a clock resynchronization. During that time the controller holds a chip-wide stall for `STALL_CYCLES` cycles (3000 by default). The threshold is a static input. The intended setting is 97 °C, which is the 100 °C limit less the ±3 °C sensor error.

A reading strictly above the threshold counts as hot. A reading strictly below it counts as cool. A reading equal to the threshold is neither, so the current state is kept. The gating and chip-wide policies engage when any unit is hot. They release only when every unit is cool.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: During and right after reset: `clk_en_o`=1, `fetch_en_o`=2'b11, `chip_scale_o`=0, `unit_scale_o`=0, `stall_o`=0, and every held reading is 0.
- R2: A decision point occurs at the clock edge that ends every `PERIOD` cycles, counted from reset release. The first one is `PERIOD` edges after release. The four throttle outputs change only at a decision point.
- R3: In mode 2'd0, at a decision point the clock-stop state is set if any held reading is above `thresh_i`. It is cleared if all readings are below `thresh_i`. Otherwise it is kept. `clk_en_o` is the inverse of this state.
- R4: In mode 2'd1, a fetch-gate state follows the same any-hot/all-cool rule. While it is set, `fetch_en_o[fetch_sel_i]` is 0 and the other bit stays 1. Bit 0 is vertex fetch and bit 1 is the rasterizer. `fetch_sel_i` is sampled at the decision point.
- R5: In mode 2'd2, `chip_scale_o` follows the same any-hot/all-cool rule.
- R6: In mode 2'd3, `unit_scale_o[k]` is set when reading k is above `thresh_i`, cleared when reading k is below it, and kept when the two are equal.
- R7: Every decision that changes `chip_scale_o` or any bit of `unit_scale_o` raises `stall_o` at that same edge. `stall_o` stays high for exactly `STALL_CYCLES` cycles. Changes in clock stop or fetch gating cause no stall.
- R8: A decision point reached while `stall_o` is high makes no decision. Readings that arrived are kept and are used at the next decision point.
- R9: At a decision point, the states of all policies other than the selected mode are released. Releasing a scaling state stalls as in R7. At most one policy is active at any time.
- R10: Each unit's held reading is replaced only in a cycle in which its own valid bit is 1. Reading k is on `samp_temp_i[k*TEMP_W +: TEMP_W]`.
- R11: A held reading equal to `thresh_i` neither engages nor releases any policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy: 0 clock stop, 1 fetch gate, 2 chip scale, 3 per-unit scale |
| fetch_sel_i | input | 1 | Stage to gate in mode 1: 0 vertex fetch, 1 rasterizer |
| thresh_i | input | TEMP_W | Trigger threshold in °C (intended 97) |
| samp_valid_i | input | NUM_UNITS | Per-unit reading strobe |
| samp_temp_i | input | NUM_UNITS*TEMP_W | Per-unit readings, unit k at bits k*TEMP_W upward |
| clk_en_o | output | 1 | Global clock enable |
| fetch_en_o | output | 2 | Fetch enables: bit 0 vertex fetch, bit 1 rasterizer |
| chip_scale_o | output | 1 | Chip-wide voltage/frequency scale request |
| unit_scale_o | output | NUM_UNITS | Per-unit clock domain scale requests |
| stall_o | output | 1 | Chip-wide stall during resynchronization |

## Verification
The hardest situation to reach is a decision point that falls inside a resynchronization stall, where the fresh readings must be kept rather than acted on. The bench builds the design with a stall longer than the period. Every scaling change therefore hides the following decision point. Random readings around the threshold, and mode switches that release scaling states, keep producing such changes. A phase in which every reading equals the threshold checks that the existing state is kept.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  typedef enum logic [1:0] {
    POL_CLK_STOP   = 2'd0,
    POL_FETCH_GATE = 2'd1,
    POL_CHIP_SCALE = 2'd2,
    POL_UNIT_SCALE = 2'd3
  } policy_e;

  // Hold-band rule: engage when over, release when under, else keep.
  function automatic logic band_next(input logic cur, input logic over, input logic under);
    logic r;
    r = cur;
    if (over) r = 1'b1;
    else if (under) r = 1'b0;
    band_next = r;
  endfunction

  // Fetch enables with one selected stage gated off.
  function automatic logic [1:0] fetch_mask(input logic gated, input logic sel);
    logic [1:0] m;
    m = 2'b11;
    if (gated) m[sel] = 1'b0;
    fetch_mask = m;
  endfunction
endpackage

// File: rtl/ttc_sample_bank.sv
module ttc_sample_bank #(
  parameter int NUM_UNITS = 4,
  parameter int TEMP_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_UNITS-1:0]        valid_i,
  input  logic [NUM_UNITS*TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0]           thresh_i,
  output logic [NUM_UNITS-1:0]        over_o,
  output logic [NUM_UNITS-1:0]        under_o
);
  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    logic [TEMP_W-1:0] held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= '0;
      else if (valid_i[g]) held_q <= temp_i[g*TEMP_W +: TEMP_W];
    end
    assign over_o[g]  = held_q > thresh_i;
    assign under_o[g] = held_q < thresh_i;
  end
endmodule

// File: rtl/ttc_period_timer.sv
module ttc_period_timer #(
  parameter int PERIOD = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic period_end_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  assign period_end_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (period_end_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ttc_stall_timer.sv
module ttc_stall_timer #(
  parameter int STALL_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(STALL_CYCLES + 1);

  logic [CW-1:0] left_q;
  assign busy_o = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else if (start_i) left_q <= CW'(STALL_CYCLES);
    else if (busy_o) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/ttc_policy.sv
module ttc_policy
  import ttc_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 decide_i,
  input  policy_e              mode_i,
  input  logic                 sel_i,
  input  logic [NUM_UNITS-1:0] over_i,
  input  logic [NUM_UNITS-1:0] under_i,
  output logic                 stop_o,
  output logic                 fgate_o,
  output logic                 sel_o,
  output logic                 chip_o,
  output logic [NUM_UNITS-1:0] unit_o,
  output logic                 scale_change_o
);
  logic any_over, all_under;
  logic stop_d, fgate_d, chip_d;
  logic [NUM_UNITS-1:0] unit_d;

  assign any_over  = |over_i;
  assign all_under = &under_i;

  always_comb begin
    stop_d  = (mode_i == POL_CLK_STOP)   ? band_next(stop_o,  any_over, all_under) : 1'b0;
    fgate_d = (mode_i == POL_FETCH_GATE) ? band_next(fgate_o, any_over, all_under) : 1'b0;
    chip_d  = (mode_i == POL_CHIP_SCALE) ? band_next(chip_o,  any_over, all_under) : 1'b0;
    for (int k = 0; k < NUM_UNITS; k++)
      unit_d[k] = (mode_i == POL_UNIT_SCALE) ? band_next(unit_o[k], over_i[k], under_i[k]) : 1'b0;
  end

  assign scale_change_o = decide_i && ((chip_d != chip_o) || (unit_d != unit_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_o  <= 1'b0;
      fgate_o <= 1'b0;
      sel_o   <= 1'b0;
      chip_o  <= 1'b0;
      unit_o  <= '0;
    end else if (decide_i) begin
      stop_o  <= stop_d;
      fgate_o <= fgate_d;
      sel_o   <= sel_i;
      chip_o  <= chip_d;
      unit_o  <= unit_d;
    end
  end
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import ttc_pkg::*;
#(
  parameter int NUM_UNITS    = 4,
  parameter int TEMP_W       = 8,
  parameter int PERIOD       = 25000,
  parameter int STALL_CYCLES = 3000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  mode_i,
  input  logic                        fetch_sel_i,
  input  logic [TEMP_W-1:0]           thresh_i,
  input  logic [NUM_UNITS-1:0]        samp_valid_i,
  input  logic [NUM_UNITS*TEMP_W-1:0] samp_temp_i,
  output logic                        clk_en_o,
  output logic [1:0]                  fetch_en_o,
  output logic                        chip_scale_o,
  output logic [NUM_UNITS-1:0]        unit_scale_o,
  output logic                        stall_o
);
  logic [NUM_UNITS-1:0] over, under;
  logic period_end, decide, scale_change;
  logic stop_q, fgate_q, sel_q;

  ttc_sample_bank #(.NUM_UNITS(NUM_UNITS), .TEMP_W(TEMP_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .valid_i(samp_valid_i), .temp_i(samp_temp_i),
    .thresh_i(thresh_i), .over_o(over), .under_o(under)
  );

  ttc_period_timer #(.PERIOD(PERIOD)) u_period (
    .clk(clk), .rst_n(rst_n), .period_end_o(period_end)
  );

  // A period end that lands inside a stall is skipped.
  assign decide = period_end && !stall_o;

  ttc_policy #(.NUM_UNITS(NUM_UNITS)) u_policy (
    .clk(clk), .rst_n(rst_n), .decide_i(decide), .mode_i(policy_e'(mode_i)),
    .sel_i(fetch_sel_i), .over_i(over), .under_i(under),
    .stop_o(stop_q), .fgate_o(fgate_q), .sel_o(sel_q), .chip_o(chip_scale_o),
    .unit_o(unit_scale_o), .scale_change_o(scale_change)
  );

  ttc_stall_timer #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
    .clk(clk), .rst_n(rst_n), .start_i(scale_change), .busy_o(stall_o)
  );

  assign clk_en_o   = !stop_q;
  assign fetch_en_o = fetch_mask(fgate_q, sel_q);
endmodule

// File: rtl/thermal_throttle_ctrl_chk.sv
module ttc_chk #(
  parameter int NUM_UNITS    = 4,
  parameter int STALL_CYCLES = 3000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clk_en_o,
  input logic [1:0]           fetch_en_o,
  input logic                 chip_scale_o,
  input logic [NUM_UNITS-1:0] unit_scale_o,
  input logic                 stall_o,
  input logic                 period_end
);
  localparam int RW = $clog2(STALL_CYCLES + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!stall_o) run_q <= '0;
    else if (run_q != RW'(STALL_CYCLES)) run_q <= run_q + 1'b1;
  end

  // R2
  outputs_at_period_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(clk_en_o) || !$stable(fetch_en_o) || !$stable(chip_scale_o) || !$stable(unit_scale_o))
      |-> $past(period_end));

  // R4
  one_stage_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~fetch_en_o) <= 1);

  // R7
  scale_change_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(chip_scale_o) || !$stable(unit_scale_o)) |-> (stall_o && !$past(stall_o)));

  // R7
  stall_not_too_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (run_q < RW'(STALL_CYCLES)));

  // R7
  stall_full_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> (run_q == RW'(STALL_CYCLES)));

  // R8
  frozen_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stall_o) |-> ($stable(clk_en_o) && $stable(fetch_en_o) &&
                        $stable(chip_scale_o) && $stable(unit_scale_o)));

  // R9
  single_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!clk_en_o, !(&fetch_en_o), chip_scale_o, |unit_scale_o}) <= 1);
endmodule

bind thermal_throttle_ctrl ttc_chk #(.NUM_UNITS(NUM_UNITS), .STALL_CYCLES(STALL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_o(clk_en_o), .fetch_en_o(fetch_en_o),
  .chip_scale_o(chip_scale_o), .unit_scale_o(unit_scale_o), .stall_o(stall_o),
  .period_end(period_end)
);

// File: tb/thermal_throttle_ctrl_tb.sv
module thermal_throttle_ctrl_tb;
  localparam int N   = 4;
  localparam int TW  = 8;
  localparam int PER = 16;
  localparam int STL = 20;   // longer than a period: exercises R8

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic fsel = 1'b0;
  logic [TW-1:0] thresh = 8'd97;
  logic [N-1:0] vld = '0;
  logic [N*TW-1:0] temp = '0;
  logic clk_en, chip_s, stall;
  logic [1:0] fen;
  logic [N-1:0] unit_s;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  thermal_throttle_ctrl #(.NUM_UNITS(N), .TEMP_W(TW), .PERIOD(PER), .STALL_CYCLES(STL)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .fetch_sel_i(fsel), .thresh_i(thresh),
    .samp_valid_i(vld), .samp_temp_i(temp), .clk_en_o(clk_en), .fetch_en_o(fen),
    .chip_scale_o(chip_s), .unit_scale_o(unit_s), .stall_o(stall)
  );

  // Reference model written from the requirements
  int m_held[N];
  int m_cnt, m_stall;
  bit m_stop, m_fg, m_sel, m_chip;
  bit [N-1:0] m_unit;
  bit hot_any, cool_all, n_stop, n_fg, n_chip;
  bit [N-1:0] n_unit;

  function automatic bit rule(bit cur, bit hot, bit cool);
    if (hot) return 1'b1;
    if (cool) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) m_held[k] = 0;
      m_cnt = 0; m_stall = 0;
      m_stop = 0; m_fg = 0; m_sel = 0; m_chip = 0; m_unit = '0;
    end else begin
      bit at_end;
      at_end = (m_cnt == PER - 1);
      if (m_stall > 0) m_stall = m_stall - 1;
      else if (at_end) begin
        hot_any = 0; cool_all = 1;
        for (int k = 0; k < N; k++) begin
          if (m_held[k] > int'(thresh)) hot_any = 1;
          if (!(m_held[k] < int'(thresh))) cool_all = 0;
        end
        n_stop = (mode == 2'd0) ? rule(m_stop, hot_any, cool_all) : 1'b0;
        n_fg   = (mode == 2'd1) ? rule(m_fg, hot_any, cool_all) : 1'b0;
        n_chip = (mode == 2'd2) ? rule(m_chip, hot_any, cool_all) : 1'b0;
        for (int k = 0; k < N; k++)
          n_unit[k] = (mode == 2'd3) ?
            rule(m_unit[k], m_held[k] > int'(thresh), m_held[k] < int'(thresh)) : 1'b0;
        if (n_chip != m_chip || n_unit != m_unit) m_stall = STL;
        m_stop = n_stop; m_fg = n_fg; m_chip = n_chip; m_unit = n_unit; m_sel = fsel;
      end
      m_cnt = at_end ? 0 : m_cnt + 1;
      for (int k = 0; k < N; k++)
        if (vld[k]) m_held[k] = int'(temp[k*TW +: TW]);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [1:0] efen;
    efen = 2'b11;
    if (m_fg) efen[m_sel] = 1'b0;
    chk("R2 R3 R11 clk_en_o", clk_en, !m_stop);
    chk("R4 R9 fetch_en_o", fen, efen);
    chk("R5 R8 chip_scale_o", chip_s, m_chip);
    chk("R6 R10 unit_scale_o", unit_s, m_unit);
    chk("R7 stall_o", stall, m_stall != 0);
  endtask

  function automatic logic [TW-1:0] pick(int style);
    case (style)
      0: return TW'(90 + $urandom_range(14));
      1: return thresh;
      2: return TW'(105 + $urandom_range(10));
      default: return TW'(80 + $urandom_range(5));
    endcase
  endfunction

  // style: temperature band; vprob: percent chance per unit of a strobe
  task automatic run_phase(int cycles, int md, int style, int vprob, bit mode_jitter);
    mode = 2'(md);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all();
      for (int k = 0; k < N; k++) begin
        vld[k] = ($urandom_range(99) < vprob);
        temp[k*TW +: TW] = pick(style);
      end
      fsel = 1'($urandom_range(1));
      if (mode_jitter && $urandom_range(40) == 0) mode = 2'($urandom_range(3));
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 clk_en_o", clk_en, 1);
    chk("R1 fetch_en_o", fen, 2'b11);
    chk("R1 chip_scale_o", chip_s, 0);
    chk("R1 unit_scale_o", unit_s, 0);
    chk("R1 stall_o", stall, 0);
    rst_n = 1'b1;
    // R2: nothing may move before the first period end even with hot readings
    vld = '1;
    for (int k = 0; k < N; k++) temp[k*TW +: TW] = 8'd120;
    repeat (PER - 2) begin
      @(negedge clk);
      chk("R2 clk_en_o early", clk_en, 1);
    end
    // directed modes, hot then threshold-equal (R11) then cool
    for (int md = 0; md < 4; md++) begin
      run_phase(3 * PER, md, 2, 100, 0);
      run_phase(3 * PER, md, 1, 100, 0);
      run_phase(4 * PER, md, 3, 100, 0);
    end
    // R9: switch away from an engaged scaling policy
    run_phase(3 * PER, 2, 2, 100, 0);
    run_phase(3 * PER, 0, 1, 100, 0);
    // random mix around the threshold, sparse strobes (R10, R8)
    for (int p = 0; p < 40; p++)
      run_phase(5 * PER, $urandom_range(3), 0, 25 + $urandom_range(50), 1);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule